// File: doc/BRIEF.md
# Self-Timed Byte Write Controller

This block puts a parallel, SRAM-like bus in front of a small register array that stands in for non-volatile byte storage. Reads work like a static RAM. A write, however, does not commit at once. A qualified write strobe latches the address and the data, so the host may reuse its buses on the next cycle. The block then runs a timed sequence on its own. It first erases the target byte to 8'hFF and then programs the latched value into it.

While that sequence runs, the block pulls an open-drain ready line low, which lets several devices share one wired-OR line. A host may watch that line. It may instead poll by reading: while busy, every read returns the complement of bit 7 of the latched byte, and after completion it returns the stored contents. A chip-clear strobe erases every location through the same timed sequence.

A filter protects against stray writes. It drops strobes that are too short, strobes taken while the supply-low input is asserted, strobes that arrive during an operation, and strobes made while the read strobe is active.

Top module: `sbw_ctrl`

## Requirements
- R1: After reset every location reads 8'hFF and `busy_pull` is 0.
- R2: `dout_en` is 1 exactly when `bus_sel_n` and `rd_strobe_n` are both 0. When idle, `dout` shows the byte at the location given by the low STORE_W bits of `addr`; the upper address bits are ignored, so those addresses alias.
- R3: A write starts at the clock where `wr_strobe_n` is seen returning high, provided that `bus_sel_n` is 0 and `rd_strobe_n` is 1 at that clock. The address and data present at that clock are latched, and later changes on `addr`/`din` have no effect on the write.
- R4: A strobe that stays low for fewer than MIN_PULSE clocks (counted while `bus_sel_n` is 0) is ignored, and a strobe of exactly MIN_PULSE clocks is accepted.
- R5: A strobe that completes while `supply_low` is 1 is ignored.
- R6: `busy_pull` is 1 for exactly WRITE_TICKS consecutive clocks, starting with the clock after the starting edge. `busy_level` is always 0.
- R7: While busy, any read returns {~d[7], 7'b0}, where d is the latched byte (8'hFF for a chip clear).
- R8: When the sequence ends, the target location holds exactly the latched byte whatever it held before, and no other location changes.
- R9: A complete write strobe made while busy is ignored and does not lengthen the busy period.
- R10: A write started with `erase_all` at 1 sets every location to 8'hFF when it ends, and its busy period is the same as that of a byte write.
- R11: A strobe made with `rd_strobe_n` at 0 is ignored, and so is a strobe made with `bus_sel_n` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel_n | input | 1 | Device select, active low |
| rd_strobe_n | input | 1 | Read output enable, active low |
| wr_strobe_n | input | 1 | Write strobe, active low; the write starts on its rising edge |
| erase_all | input | 1 | When 1 at the starting edge, the strobe clears the whole array |
| supply_low | input | 1 | Low-supply flag; blocks writes |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data from the host |
| dout | output | 8 | Read data or polling status |
| dout_en | output | 1 | Drive enable for the data bus |
| busy_pull | output | 1 | Open-drain enable for the ready line (1 = pulling low) |
| busy_level | output | 1 | Level driven when `busy_pull` is 1 (always 0) |

## Verification
The hardest case to reach is a full, well-formed strobe that arrives in the middle of a running sequence. From the outside it looks exactly like a legal write. Only the earlier start shows that it must be dropped, and its effect appears only once the first write has ended. The bench raises this strobe a few clocks into a busy period, aimed at a different location. It then measures that the busy run still has the nominal length and reads back that the second location kept its old value. A second hard case is the erase-then-program order: every location is first written with one pattern and then overwritten with that pattern's complement mixed with its index, so a result ANDed with the old contents would show.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ERASE = 2'd1,
        SEQ_PROG  = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_NONE      = 2'd0,
        OP_ERASE_ONE = 2'd1,
        OP_ERASE_ALL = 2'd2,
        OP_PROGRAM   = 2'd3
    } store_op_e;

    typedef struct packed {
        logic       wipe;
        logic [7:0] data;
    } wr_job_t;

    // Status byte shown on reads while a sequence runs.
    function automatic logic [7:0] poll_byte(input logic [7:0] d);
        return {~d[7], 7'b000_0000};
    endfunction

    function automatic int unsigned erase_share(input int unsigned total);
        return (total / 2 == 0) ? 1 : total / 2;
    endfunction

endpackage

// File: rtl/sbw_strobe_filter.sv
module sbw_strobe_filter #(
    parameter int unsigned MIN_PULSE = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_sel_n,
    input  logic rd_strobe_n,
    input  logic wr_strobe_n,
    input  logic supply_low,
    output logic fire
);
    localparam int unsigned CW = $clog2(MIN_PULSE + 1) + 1;
    localparam logic [CW-1:0] MIN_C = CW'(MIN_PULSE);

    logic          wr_q;
    logic [CW-1:0] low_cnt;
    logic          wide_enough;
    logic          qualified;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q    <= 1'b1;
            low_cnt <= '0;
        end else begin
            wr_q <= wr_strobe_n;
            if (!wr_strobe_n && !bus_sel_n) begin
                if (low_cnt != MIN_C) begin
                    low_cnt <= low_cnt + 1'b1;
                end
            end else begin
                low_cnt <= '0;
            end
        end
    end

    always_comb begin
        wide_enough = (low_cnt >= MIN_C);
        qualified   = !bus_sel_n && rd_strobe_n && !supply_low;
        fire        = !wr_q && wr_strobe_n && qualified && wide_enough;
    end

endmodule

// File: rtl/sbw_sequencer.sv
module sbw_sequencer
    import sbw_pkg::*;
#(
    parameter int unsigned STORE_W     = 8,
    parameter int unsigned WRITE_TICKS = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fire,
    input  logic               wipe_req,
    input  logic [STORE_W-1:0] addr_in,
    input  logic [7:0]         data_in,
    output logic               busy,
    output wr_job_t            job,
    output logic [STORE_W-1:0] job_addr,
    output store_op_e          op
);
    localparam int unsigned ERASE_TICKS = erase_share(WRITE_TICKS);
    localparam int unsigned PROG_TICKS  = WRITE_TICKS - ERASE_TICKS;
    localparam int unsigned TW          = $clog2(WRITE_TICKS + 1) + 1;
    localparam logic [TW-1:0] ERASE_LAST = TW'(ERASE_TICKS - 1);
    localparam logic [TW-1:0] PROG_LAST  = TW'(PROG_TICKS - 1);

    seq_state_e    state;
    logic [TW-1:0] tick;
    logic          erase_done;
    logic          prog_done;

    always_comb begin
        erase_done = (state == SEQ_ERASE) && (tick == ERASE_LAST);
        prog_done  = (state == SEQ_PROG)  && (tick == PROG_LAST);
        busy       = (state != SEQ_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SEQ_IDLE;
            tick     <= '0;
            job      <= '{wipe: 1'b0, data: ERASED_BYTE};
            job_addr <= '0;
        end else begin
            unique case (state)
                SEQ_IDLE: begin
                    if (fire) begin
                        job.wipe <= wipe_req;
                        job.data <= wipe_req ? ERASED_BYTE : data_in;
                        job_addr <= addr_in;
                        tick     <= '0;
                        state    <= SEQ_ERASE;
                    end
                end
                SEQ_ERASE: begin
                    if (erase_done) begin
                        tick  <= '0;
                        state <= SEQ_PROG;
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                SEQ_PROG: begin
                    if (prog_done) begin
                        tick  <= '0;
                        state <= SEQ_IDLE;
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                default: begin
                    tick  <= '0;
                    state <= SEQ_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        op = OP_NONE;
        if (erase_done) begin
            op = job.wipe ? OP_ERASE_ALL : OP_ERASE_ONE;
        end else if (prog_done && !job.wipe) begin
            op = OP_PROGRAM;
        end
    end

endmodule

// File: rtl/sbw_store.sv
module sbw_store
    import sbw_pkg::*;
#(
    parameter int unsigned STORE_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  store_op_e          op,
    input  logic [STORE_W-1:0] op_addr,
    input  logic [7:0]         op_data,
    input  logic [STORE_W-1:0] rd_addr,
    output logic [7:0]         rd_data
);
    localparam int unsigned DEPTH = 1 << STORE_W;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= ERASED_BYTE;
            end
        end else begin
            unique case (op)
                OP_ERASE_ONE: cells[op_addr] <= ERASED_BYTE;
                OP_ERASE_ALL: begin
                    for (int i = 0; i < DEPTH; i++) begin
                        cells[i] <= ERASED_BYTE;
                    end
                end
                OP_PROGRAM:   cells[op_addr] <= op_data;
                default:      ;
            endcase
        end
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/sbw_ctrl.sv
module sbw_ctrl
    import sbw_pkg::*;
#(
    parameter int unsigned ADDR_W      = 13,
    parameter int unsigned STORE_W     = 8,
    parameter int unsigned WRITE_TICKS = 375000,
    parameter int unsigned MIN_PULSE   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel_n,
    input  logic              rd_strobe_n,
    input  logic              wr_strobe_n,
    input  logic              erase_all,
    input  logic              supply_low,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en,
    output logic              busy_pull,
    output logic              busy_level
);
    logic               fire;
    logic               busy;
    wr_job_t            job;
    logic [STORE_W-1:0] lat_addr;
    logic [7:0]         lat_data;
    store_op_e          op;
    logic [7:0]         cell_q;
    logic [STORE_W-1:0] win_addr;

    assign win_addr = addr[STORE_W-1:0];

    generate
        if (ADDR_W > STORE_W) begin : g_alias
            logic unused_hi;
            assign unused_hi = ^addr[ADDR_W-1:STORE_W];
        end
    endgenerate

    sbw_strobe_filter #(.MIN_PULSE(MIN_PULSE)) filt_i (
        .clk         (clk),
        .rst         (rst),
        .bus_sel_n   (bus_sel_n),
        .rd_strobe_n (rd_strobe_n),
        .wr_strobe_n (wr_strobe_n),
        .supply_low  (supply_low),
        .fire        (fire)
    );

    sbw_sequencer #(.STORE_W(STORE_W), .WRITE_TICKS(WRITE_TICKS)) seq_i (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .wipe_req (erase_all),
        .addr_in  (win_addr),
        .data_in  (din),
        .busy     (busy),
        .job      (job),
        .job_addr (lat_addr),
        .op       (op)
    );

    assign lat_data = job.data;

    sbw_store #(.STORE_W(STORE_W)) store_i (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .op_addr (lat_addr),
        .op_data (lat_data),
        .rd_addr (win_addr),
        .rd_data (cell_q)
    );

    always_comb begin
        dout_en    = !bus_sel_n && !rd_strobe_n;
        dout       = busy ? poll_byte(lat_data) : cell_q;
        busy_pull  = busy;
        busy_level = 1'b0;
    end

endmodule

// File: rtl/sbw_ctrl_chk.sv
module sbw_ctrl_chk #(
    parameter int unsigned WRITE_TICKS = 16,
    parameter int unsigned STORE_W     = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               busy,
    input logic               fire,
    input logic               wr_strobe_n,
    input logic               bus_sel_n,
    input logic               rd_strobe_n,
    input logic               supply_low,
    input logic [7:0]         lat_data,
    input logic [STORE_W-1:0] lat_addr
);
    logic [31:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
        end else if (busy) begin
            run_cnt <= run_cnt + 1;
        end else begin
            run_cnt <= '0;
        end
    end

    assert_busy_len_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_cnt == WRITE_TICKS));

    assert_start_on_fire_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(fire));

    assert_latch_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(lat_data) && $stable(lat_addr)));

    assert_supply_block_R5: assert property (@(posedge clk) disable iff (rst)
        fire |-> !supply_low);

    assert_fire_edge_R11: assert property (@(posedge clk) disable iff (rst)
        fire |-> (wr_strobe_n && !$past(wr_strobe_n) && !bus_sel_n && rd_strobe_n));

endmodule

bind sbw_ctrl sbw_ctrl_chk #(
    .WRITE_TICKS (WRITE_TICKS),
    .STORE_W     (STORE_W)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .fire        (fire),
    .wr_strobe_n (wr_strobe_n),
    .bus_sel_n   (bus_sel_n),
    .rd_strobe_n (rd_strobe_n),
    .supply_low  (supply_low),
    .lat_data    (lat_data),
    .lat_addr    (lat_addr)
);

// File: tb/sbw_ctrl_tb_top.sv
`timescale 1ns/1ps
module sbw_ctrl_tb_top;
    localparam int AW = 13;
    localparam int SW = 4;
    localparam int WT = 12;
    localparam int MP = 3;
    localparam int N  = 1 << SW;

    logic          clk = 1'b0;
    logic          rst;
    logic          bus_sel_n, rd_strobe_n, wr_strobe_n, erase_all, supply_low;
    logic [AW-1:0] addr;
    logic [7:0]    din;
    logic [7:0]    dout;
    logic          dout_en, busy_pull, busy_level;

    int total = 0;
    int bad   = 0;
    logic [7:0] model [N];

    always #4 clk = ~clk;

    sbw_ctrl #(.ADDR_W(AW), .STORE_W(SW), .WRITE_TICKS(WT), .MIN_PULSE(MP)) dut_i (
        .clk(clk), .rst(rst), .bus_sel_n(bus_sel_n), .rd_strobe_n(rd_strobe_n),
        .wr_strobe_n(wr_strobe_n), .erase_all(erase_all), .supply_low(supply_low),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .busy_pull(busy_pull), .busy_level(busy_level)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic read_at(input int a, input logic [7:0] exp, input string req);
        @(negedge clk);
        addr = AW'(a); bus_sel_n = 1'b0; rd_strobe_n = 1'b0;
        #1;
        check(dout_en == 1'b1, "R2 dout_en on read", dout_en, 1);
        check(dout == exp, req, dout, exp);
        rd_strobe_n = 1'b1;
    endtask

    task automatic read_all(input string req);
        for (int a = 0; a < N; a++) begin
            read_at(a, model[a], req);
        end
    endtask

    // Strobe: low for width clocks, then release; the start edge is the next posedge.
    task automatic strobe(input int a, input logic [7:0] d, input int width, input bit wipe);
        @(negedge clk);
        addr = AW'(a); din = d; erase_all = wipe;
        bus_sel_n = 1'b0; rd_strobe_n = 1'b1; wr_strobe_n = 1'b0;
        repeat (width) @(negedge clk);
        wr_strobe_n = 1'b1;
    endtask

    // Counts busy clocks after a strobe; optionally polls or intrudes with a second strobe.
    task automatic watch(input int exp_busy, input bit do_poll, input logic [7:0] poll_exp,
                         input bit intrude, input int a2, input logic [7:0] d2, output int cnt);
        cnt = 0;
        for (int i = 0; i < WT + 8; i++) begin
            @(negedge clk);
            if (i == 0) begin
                addr = ~addr; din = ~din; erase_all = 1'b0;   // R3: bus reused at once
            end
            if (do_poll && i == 1) begin
                bus_sel_n = 1'b0; rd_strobe_n = 1'b0;
                #1;
                check(dout == poll_exp, "R7 poll while busy", dout, poll_exp);
                rd_strobe_n = 1'b1;
            end
            if (intrude && i == 2) begin
                addr = AW'(a2); din = d2; bus_sel_n = 1'b0; wr_strobe_n = 1'b0;
            end
            if (intrude && i == 2 + MP + 1) wr_strobe_n = 1'b1;
            #1;
            if (busy_pull) cnt++;
            if (busy_level !== 1'b0) check(1'b0, "R6 busy_level", busy_level, 0);
        end
        check(cnt == exp_busy, "R6 busy length", cnt, exp_busy);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int c;
        logic [7:0] d;
        rst = 1'b1; bus_sel_n = 1'b1; rd_strobe_n = 1'b1; wr_strobe_n = 1'b1;
        erase_all = 1'b0; supply_low = 1'b0; addr = '0; din = '0;
        for (int a = 0; a < N; a++) model[a] = 8'hFF;
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        check(busy_pull == 1'b0, "R1 ready after reset", busy_pull, 0);
        read_all("R1 erased after reset");

        // R2: enable needs both select and read strobe
        @(negedge clk); bus_sel_n = 1'b0; rd_strobe_n = 1'b1; #1;
        check(dout_en == 1'b0, "R2 no drive without read strobe", dout_en, 0);
        bus_sel_n = 1'b1; rd_strobe_n = 1'b0; #1;
        check(dout_en == 1'b0, "R2 no drive without select", dout_en, 0);
        rd_strobe_n = 1'b1;

        // R3 R6 R7 R8: sweep every location with aliased addresses, minimum width (R4 boundary)
        for (int a = 0; a < N; a++) begin
            d = 8'((a * 29 + 7) & 255);
            strobe(a | (((a * 3) & 7) << SW), d, MP, 1'b0);
            watch(WT, 1'b1, {~d[7], 7'b0}, 1'b0, 0, 8'h00, c);
            model[a] = d;
        end
        read_all("R8 first pattern");
        for (int a = 0; a < N; a++) read_at(a | (5 << SW), model[a], "R2 alias read");

        // R8: overwrite, result must not be old AND new
        for (int a = 0; a < N; a++) begin
            d = ~model[a] ^ 8'(a);
            strobe(a, d, MP + 2, 1'b0);
            watch(WT, 1'b1, {~d[7], 7'b0}, 1'b0, 0, 8'h00, c);
            model[a] = d;
        end
        read_all("R8 overwrite");

        // R4: one clock short
        strobe(3, 8'h5A, MP - 1, 1'b0);
        watch(0, 1'b0, 8'h00, 1'b0, 0, 8'h00, c);
        read_at(3, model[3], "R4 short strobe ignored");

        // R5: supply low
        supply_low = 1'b1;
        strobe(4, 8'hA5, MP + 1, 1'b0);
        watch(0, 1'b0, 8'h00, 1'b0, 0, 8'h00, c);
        supply_low = 1'b0;
        read_at(4, model[4], "R5 supply-low write ignored");

        // R11: read strobe active during write, and deselected write
        @(negedge clk);
        addr = 5; din = 8'h33; bus_sel_n = 1'b0; rd_strobe_n = 1'b0; wr_strobe_n = 1'b0;
        repeat (MP + 1) @(negedge clk);
        wr_strobe_n = 1'b1;
        watch(0, 1'b0, 8'h00, 1'b0, 0, 8'h00, c);
        rd_strobe_n = 1'b1;
        read_at(5, model[5], "R11 write with read strobe ignored");
        @(negedge clk);
        addr = 6; din = 8'h44; bus_sel_n = 1'b1; wr_strobe_n = 1'b0;
        repeat (MP + 1) @(negedge clk);
        wr_strobe_n = 1'b1;
        watch(0, 1'b0, 8'h00, 1'b0, 0, 8'h00, c);
        read_at(6, model[6], "R11 deselected write ignored");

        // R9: full strobe while busy to another location
        strobe(7, 8'h12, MP, 1'b0);
        watch(WT, 1'b0, 8'h00, 1'b1, 8, 8'hC3, c);
        model[7] = 8'h12;
        read_at(8, model[8], "R9 strobe while busy ignored");
        read_at(7, 8'h12, "R9 first write intact");

        // R10: chip clear
        strobe(9, 8'h00, MP, 1'b1);
        watch(WT, 1'b1, 8'h00, 1'b0, 0, 8'h00, c);
        for (int a = 0; a < N; a++) model[a] = 8'hFF;
        read_all("R10 chip clear");

        // R3: a normal write after the clear
        strobe(2, 8'h0F, MP, 1'b0);
        watch(WT, 1'b1, 8'h80, 1'b0, 0, 8'h00, c);
        model[2] = 8'h0F;
        read_all("R3 write after clear");

        finish_run();
    end
endmodule